// File: doc/BRIEF.md
# Power-Gated Unit Sleep/Wake Controller

This controller drives the sleep transistors of one power-gated execution unit, for example a floating-point unit. It watches three inputs. The first says the unit is idle. The second is an early hint from decode that an instruction for the unit has been seen. The third is a request from execution. From these it decides when to cut power and when to restore it.

Sleep is entered only after the idle input has stayed high for a programmable number of cycles. Once asleep, the unit stays off for a programmable minimum residency, so that each sleep period is long enough to recover the energy spent discharging and recharging the gated rail. A wake request that arrives inside that window is held and acted on when the window ends.

Power returns progressively to limit the inrush current. The segment enables switch on one at a time, one more segment every programmable number of cycles. A ready flag tells issue logic that the unit can accept work again. Issue must hold any instruction for the unit while the flag is low.

Top module: `pg_sleep_ctrl`

## Requirements
- R1: After reset the unit is powered: every bit of `segEnable` is 1 and `unitReady` is 1.
- R2: While powered, sleep entry begins only after `unitIdle` has been sampled high, with `wakeHint` and `execReq` both low, on `cfgIdleLimit` consecutive clock edges (a value of 0 acts as 1). Any other sample restarts the count. Entry first gives one drain cycle in which `unitReady` is 0 and all segments are still on. In the next cycle all segments are off.
- R3: While powered, `wakeHint` and `execReq` leave `segEnable` and `unitReady` unchanged. Each one clears the idle count on the edge at which it is sampled.
- R4: Once all segments are off, they stay off for at least `cfgMinSleep` cycles (a value of 0 acts as 1), whatever requests arrive.
- R5: A request (`wakeHint` or `execReq`) sampled during the drain cycle or during the residency window is remembered. Wakeup then begins in the cycle right after the last residency cycle, with no further request needed.
- R6: If the residency window has already elapsed, a request sampled at a clock edge makes wakeup begin in the cycle that follows that edge. With no request, the unit stays asleep for as long as it is idle.
- R7: In the first wakeup cycle only bit 0 of `segEnable` is 1. After that, one more bit turns on, counting upward from bit 0, every `cfgStepGap` cycles (a value of 0 acts as 1). `segEnable` is always a run of ones starting at bit 0.
- R8: `unitReady` rises exactly one cycle after the last segment turns on. It is 0 whenever any segment is off.
- R9: While waking, the inputs `unitIdle`, `wakeHint` and `execReq` do not change the timing of the segment steps or of the ready flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| unitIdle | input | 1 | The unit has no work this cycle |
| wakeHint | input | 1 | Decode has seen an instruction for the unit |
| execReq | input | 1 | An instruction wants to execute on the unit |
| cfgIdleLimit | input | CNT_W | Consecutive idle cycles needed before sleep |
| cfgMinSleep | input | CNT_W | Minimum number of cycles to stay asleep |
| cfgStepGap | input | CNT_W | Cycles between successive segment turn-ons |
| segEnable | output | NUM_SEGS | Sleep-transistor segment enables, thermometer coded |
| unitReady | output | 1 | The unit is fully powered and may accept issue |

## Verification
The bench builds the block with NUM_SEGS=5 and CNT_W=6. Five segments give four step intervals, so off-by-one errors in the step spacing add up to a visible shift before ready rises. The narrow configuration width makes the zero settings of all three limits easy to reach, and those settings must behave exactly like one. Idle threshold, residency and step gap are varied from 0 to 5 across the scenarios. These cover: a request held from the drain cycle, a request held from inside the residency window, a late request long after the residency has ended, and a request held high for the whole of wakeup.

// File: rtl/pg_sleep_pkg.sv
`timescale 1ns/1ps
package pg_sleep_pkg;

  // Controller states; ON is the powered state entered from reset
  typedef enum logic [1:0] {
    PG_ON     = 2'd0,
    PG_DRAIN  = 2'd1,
    PG_ASLEEP = 2'd2,
    PG_WAKE   = 2'd3
  } pgState_e;

  // Counters held in the datapath
  localparam int PG_NCNT  = 3;
  localparam int CI_IDLE  = 0;
  localparam int CI_RES   = 1;
  localparam int CI_GAP   = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic [PG_NCNT-1:0] cntClr;
    logic [PG_NCNT-1:0] cntInc;
    logic               segZero;
    logic               segFirst;
    logic               segStep;
    logic               pendSet;
    logic               pendClr;
  } pgStrobe_t;

  // Status flags from datapath to control
  typedef struct packed {
    logic [PG_NCNT-1:0] cntDone;
    logic               segFull;
    logic               pendQ;
  } pgStatus_t;

endpackage

// File: rtl/pg_sat_counter.sv
`timescale 1ns/1ps
module pg_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         reached
);

  localparam logic [W-1:0] MAXV = '1;

  logic [W:0] nextVal;

  // reached means this cycle completes the count; a limit of 0 acts like 1
  assign nextVal = {1'b0, count} + 1'b1;
  assign reached = (nextVal >= {1'b0, limit});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && (count != MAXV)) begin
      count <= nextVal[W-1:0];
    end
  end

endmodule

// File: rtl/pg_sleep_dp.sv
`timescale 1ns/1ps
module pg_sleep_dp
  import pg_sleep_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  pgStrobe_t           strobe,
  input  logic [CNT_W-1:0]    cfgIdleLimit,
  input  logic [CNT_W-1:0]    cfgMinSleep,
  input  logic [CNT_W-1:0]    cfgStepGap,
  output pgStatus_t           status,
  output logic [NUM_SEGS-1:0] segEnable
);

  localparam int SEG_CW = $clog2(NUM_SEGS + 1);
  localparam logic [SEG_CW-1:0] SEG_ALL = SEG_CW'(NUM_SEGS);

  logic [CNT_W-1:0]   cntLimit [PG_NCNT];
  logic [CNT_W-1:0]   cntValue [PG_NCNT];
  logic [PG_NCNT-1:0] cntDone;
  logic [SEG_CW-1:0]  segCnt;
  logic               pendQ;

  assign cntLimit[CI_IDLE] = cfgIdleLimit;
  assign cntLimit[CI_RES]  = cfgMinSleep;
  assign cntLimit[CI_GAP]  = cfgStepGap;

  // Idle run, residency and step-gap counters share one structure
  for (genvar c = 0; c < PG_NCNT; c++) begin : gCnt
    pg_sat_counter #(.W(CNT_W)) cnt_i (
      .clk     (clk),
      .rstN    (rstN),
      .clr     (strobe.cntClr[c]),
      .inc     (strobe.cntInc[c]),
      .limit   (cntLimit[c]),
      .count   (cntValue[c]),
      .reached (cntDone[c])
    );
  end

  // Number of powered segments; reset leaves the unit fully on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segCnt <= SEG_ALL;
    end else if (strobe.segZero) begin
      segCnt <= '0;
    end else if (strobe.segFirst) begin
      segCnt <= SEG_CW'(1);
    end else if (strobe.segStep && (segCnt != SEG_ALL)) begin
      segCnt <= segCnt + 1'b1;
    end
  end

  // Wake request remembered during drain and residency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (strobe.pendClr) begin
      pendQ <= 1'b0;
    end else if (strobe.pendSet) begin
      pendQ <= 1'b1;
    end
  end

  // Thermometer decode of the segment count
  for (genvar s = 0; s < NUM_SEGS; s++) begin : gSeg
    assign segEnable[s] = (segCnt > SEG_CW'(s));
  end

  assign status.cntDone = cntDone;
  assign status.segFull = (segCnt == SEG_ALL);
  assign status.pendQ   = pendQ;

endmodule

// File: rtl/pg_sleep_fsm.sv
`timescale 1ns/1ps
module pg_sleep_fsm
  import pg_sleep_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      unitIdle,
  input  logic      wakeHint,
  input  logic      execReq,
  input  pgStatus_t status,
  output pgStrobe_t strobe,
  output logic      unitReady
);

  pgState_e state, stateNext;
  logic     wakeNow;
  logic     idleNow;

  assign wakeNow = wakeHint | execReq;
  assign idleNow = unitIdle & ~wakeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PG_ON;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      PG_ON: begin
        if (idleNow) begin
          if (status.cntDone[CI_IDLE]) begin
            stateNext                = PG_DRAIN;
            strobe.cntClr[CI_IDLE]   = 1'b1;
          end else begin
            strobe.cntInc[CI_IDLE]   = 1'b1;
          end
        end else begin
          strobe.cntClr[CI_IDLE]     = 1'b1;
        end
      end
      PG_DRAIN: begin
        // Entry is committed; a request here is only remembered
        stateNext               = PG_ASLEEP;
        strobe.cntClr[CI_IDLE]  = 1'b1;
        strobe.cntClr[CI_RES]   = 1'b1;
        strobe.segZero          = 1'b1;
        strobe.pendSet          = wakeNow;
      end
      PG_ASLEEP: begin
        strobe.cntClr[CI_IDLE] = 1'b1;
        if (status.cntDone[CI_RES] && (status.pendQ || wakeNow)) begin
          stateNext             = PG_WAKE;
          strobe.segFirst       = 1'b1;
          strobe.cntClr[CI_GAP] = 1'b1;
          strobe.pendClr        = 1'b1;
        end else begin
          strobe.cntInc[CI_RES] = 1'b1;
          strobe.pendSet        = wakeNow;
        end
      end
      PG_WAKE: begin
        strobe.cntClr[CI_IDLE] = 1'b1;
        if (status.segFull) begin
          stateNext             = PG_ON;
        end else if (status.cntDone[CI_GAP]) begin
          strobe.segStep        = 1'b1;
          strobe.cntClr[CI_GAP] = 1'b1;
        end else begin
          strobe.cntInc[CI_GAP] = 1'b1;
        end
      end
      default: stateNext = PG_ON;
    endcase
  end

  assign unitReady = (state == PG_ON);

endmodule

// File: rtl/pg_sleep_ctrl.sv
`timescale 1ns/1ps
module pg_sleep_ctrl
  import pg_sleep_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                unitIdle,
  input  logic                wakeHint,
  input  logic                execReq,
  input  logic [CNT_W-1:0]    cfgIdleLimit,
  input  logic [CNT_W-1:0]    cfgMinSleep,
  input  logic [CNT_W-1:0]    cfgStepGap,
  output logic [NUM_SEGS-1:0] segEnable,
  output logic                unitReady
);

  pgStrobe_t strobe;
  pgStatus_t status;

  pg_sleep_fsm fsm_i (
    .clk       (clk),
    .rstN      (rstN),
    .unitIdle  (unitIdle),
    .wakeHint  (wakeHint),
    .execReq   (execReq),
    .status    (status),
    .strobe    (strobe),
    .unitReady (unitReady)
  );

  pg_sleep_dp #(
    .NUM_SEGS (NUM_SEGS),
    .CNT_W    (CNT_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgIdleLimit (cfgIdleLimit),
    .cfgMinSleep  (cfgMinSleep),
    .cfgStepGap   (cfgStepGap),
    .status       (status),
    .segEnable    (segEnable)
  );

endmodule

// File: rtl/pg_sleep_chk.sv
`timescale 1ns/1ps
module pg_sleep_chk #(
  parameter int NUM_SEGS = 4,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                unitIdle,
  input  logic                wakeHint,
  input  logic                execReq,
  input  logic [CNT_W-1:0]    cfgIdleLimit,
  input  logic [CNT_W-1:0]    cfgMinSleep,
  input  logic [CNT_W-1:0]    cfgStepGap,
  input  logic [NUM_SEGS-1:0] segEnable,
  input  logic                unitReady
);

  localparam int RW = CNT_W + 1;
  localparam logic [RW-1:0] RMAX = '1;

  logic [RW-1:0]       idleRun;
  logic [RW-1:0]       sleepRun;
  logic [RW-1:0]       holdRun;
  logic [NUM_SEGS-1:0] segQ;
  logic [NUM_SEGS-1:0] segPlus;

  function automatic logic [RW-1:0] effOf(input logic [CNT_W-1:0] v);
    return (v == '0) ? RW'(1) : {1'b0, v};
  endfunction

  assign segPlus = segEnable + NUM_SEGS'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleRun  <= '0;
      sleepRun <= '0;
      holdRun  <= '0;
      segQ     <= '1;
    end else begin
      if (unitIdle && !wakeHint && !execReq) begin
        idleRun <= (idleRun == RMAX) ? idleRun : idleRun + 1'b1;
      end else begin
        idleRun <= '0;
      end
      if (segEnable == '0) begin
        sleepRun <= (sleepRun == RMAX) ? sleepRun : sleepRun + 1'b1;
      end else begin
        sleepRun <= '0;
      end
      if (segEnable == segQ) begin
        holdRun <= (holdRun == RMAX) ? holdRun : holdRun + 1'b1;
      end else begin
        holdRun <= RW'(1);
      end
      segQ <= segEnable;
    end
  end

  // R2
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unitReady) |-> (idleRun >= effOf(cfgIdleLimit)));

  // R2
  drain_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unitReady) |=> (segEnable == '0));

  // R4
  min_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((segEnable != '0) && (segQ == '0)) |-> (sleepRun >= effOf(cfgMinSleep)));

  // R7
  therm_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((segEnable & segPlus) == '0));

  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(segEnable) > $countones($past(segEnable)))
      |-> ($countones(segEnable) == $countones($past(segEnable)) + 1));

  // R7
  step_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((segQ != '0) && ($countones(segEnable) > $countones(segQ)))
      |-> (holdRun == effOf(cfgStepGap)));

  // R8
  ready_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    unitReady |-> (segEnable == '1));

  // R8
  ready_after_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(segEnable == '1) |=> unitReady);

endmodule

bind pg_sleep_ctrl pg_sleep_chk #(
  .NUM_SEGS (NUM_SEGS),
  .CNT_W    (CNT_W)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .unitIdle     (unitIdle),
  .wakeHint     (wakeHint),
  .execReq      (execReq),
  .cfgIdleLimit (cfgIdleLimit),
  .cfgMinSleep  (cfgMinSleep),
  .cfgStepGap   (cfgStepGap),
  .segEnable    (segEnable),
  .unitReady    (unitReady)
);

// File: tb/pg_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module pg_sleep_ctrl_tb_top;

  localparam int S  = 5;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          unitIdle = 1'b0;
  logic          wakeHint = 1'b0;
  logic          execReq = 1'b0;
  logic [CW-1:0] cfgIdleLimit = '0;
  logic [CW-1:0] cfgMinSleep = '0;
  logic [CW-1:0] cfgStepGap = '0;
  logic [S-1:0]  segEnable;
  logic          unitReady;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pg_sleep_ctrl #(.NUM_SEGS(S), .CNT_W(CW)) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .unitIdle     (unitIdle),
    .wakeHint     (wakeHint),
    .execReq      (execReq),
    .cfgIdleLimit (cfgIdleLimit),
    .cfgMinSleep  (cfgMinSleep),
    .cfgStepGap   (cfgStepGap),
    .segEnable    (segEnable),
    .unitReady    (unitReady)
  );

  function automatic int therm(input int k);
    return (1 << k) - 1;
  endfunction

  function automatic int effOf(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input bit i, input bit h, input bit r);
    unitIdle = i;
    wakeHint = h;
    execReq  = r;
  endtask

  task automatic setCfg(input int l, input int m, input int g);
    cfgIdleLimit = CW'(l);
    cfgMinSleep  = CW'(m);
    cfgStepGap   = CW'(g);
  endtask

  task automatic expectOut(input string tag, input int ones, input bit rdy);
    check(int'(segEnable) == therm(ones), {tag, " segEnable"}, int'(segEnable), therm(ones));
    check(unitReady == rdy, {tag, " unitReady"}, int'(unitReady), int'(rdy));
  endtask

  // R2: idle run, drain cycle, then all off; ends in the first asleep cycle
  task automatic enterSleep(input int lim, input bit hintInDrain);
    drive(1'b1, 1'b0, 1'b0);
    for (int k = 1; k < effOf(lim); k++) begin
      tick();
      expectOut("R2 idle count", S, 1'b1);
    end
    tick();
    expectOut("R2 drain", S, 1'b0);
    if (hintInDrain) drive(1'b1, 1'b1, 1'b0);
    tick();
    drive(1'b1, 1'b0, 1'b0);
    expectOut("R2 asleep", 0, 1'b0);
  endtask

  // R7 R8 R9: called in the first wake cycle, already checked
  task automatic checkWake(input int gap, input bit keepReq);
    int g;
    g = effOf(gap);
    for (int c = 1; c <= (S - 1) * g; c++) begin
      drive(c[0], c[0], keepReq);   // R9 noise on inputs while waking
      tick();
      expectOut("R7 R9 step", 1 + c / g, 1'b0);
    end
    drive(1'b0, 1'b0, keepReq);
    tick();
    expectOut("R8 ready", S, 1'b1);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    expectOut("R1 reset", S, 1'b1);
  endtask

  task automatic tIdleFilter();
    setCfg(3, 4, 1);
    drive(1'b1, 1'b0, 1'b0);
    repeat (2) tick();
    expectOut("R2 two idle", S, 1'b1);
    drive(1'b1, 1'b1, 1'b0);
    tick();
    expectOut("R3 hint in ON", S, 1'b1);
    drive(1'b1, 1'b0, 1'b0);
    repeat (2) tick();
    expectOut("R3 count restarted after hint", S, 1'b1);
    drive(1'b1, 1'b0, 1'b1);
    tick();
    expectOut("R3 request in ON", S, 1'b1);
    drive(1'b1, 1'b0, 1'b0);
    repeat (2) tick();
    expectOut("R2 count restarted after request", S, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    tick();
    expectOut("R2 idle dropped", S, 1'b1);
  endtask

  task automatic tHeldWake();
    setCfg(3, 5, 2);
    enterSleep(3, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    tick();
    drive(1'b1, 1'b0, 1'b0);
    expectOut("R5 request held", 0, 1'b0);
    for (int k = 3; k <= 5; k++) begin
      tick();
      expectOut("R4 residency", 0, 1'b0);
    end
    tick();
    expectOut("R5 wake after residency", 1, 1'b0);
    checkWake(2, 1'b0);
  endtask

  task automatic tDrainHint();
    setCfg(2, 3, 3);
    enterSleep(2, 1'b1);
    for (int k = 2; k <= 3; k++) begin
      tick();
      expectOut("R4 residency after drain hint", 0, 1'b0);
    end
    tick();
    expectOut("R5 drain hint remembered", 1, 1'b0);
    checkWake(3, 1'b0);
  endtask

  task automatic tLateReq();
    setCfg(2, 2, 1);
    enterSleep(2, 1'b0);
    for (int k = 2; k <= 9; k++) begin
      tick();
      expectOut("R6 stays asleep", 0, 1'b0);
    end
    drive(1'b0, 1'b0, 1'b1);
    tick();
    expectOut("R6 late request", 1, 1'b0);
    checkWake(1, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    tick();
    expectOut("R3 request after wake", S, 1'b1);
  endtask

  task automatic tZeroCfg();
    setCfg(0, 0, 0);
    enterSleep(0, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    tick();
    expectOut("R4 zero residency acts as one", 1, 1'b0);
    checkWake(0, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    tReset();
    tIdleFilter();
    tHeldWake();
    tDrainHint();
    tLateReq();
    tZeroCfg();
    repeat (2) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule